// File: doc/BRIEF.md
# Shifted Constant Insertion Unit

This unit carries out the load-constant instruction family against one wide register word. Each cycle it may accept a decoded 32-bit instruction together with the present contents of the destination register. It drops a 16-bit constant into one 16-bit lane of that word. The lane is picked by a 4-bit shift field. A wide register can therefore be assembled over several instructions, one lane at a time.

One opcode bit picks the variant. The plain variant keeps every other bit of the old value. The extending variant copies the constant's top bit into every lane above the chosen one, and keeps the lanes below it. The result is registered and leaves the unit one cycle later as a write-back value, a destination index and a write strobe.

The register width is a parameter, 64 bits by default, and must be a multiple of 16 up to 256. Register storage, hazard tracking and all other opcodes belong to neighbouring blocks.

Top module: `const_lane_insert`

## Requirements
- R1: An instruction belongs to the family only when bits 31:27 equal the parameter `OPC_MATCH` (default 5'b10110). Any other value causes neither a write nor a lane error.
- R2: Bits 25:22 form the lane number k. The constant, taken from bits 21:6, appears in `wr_data` bits [16k+15:16k].
- R3: When bit 26 is 0, every bit of `wr_data` outside the chosen lane equals the corresponding bit of `in_old`.
- R4: When bit 26 is 1, every bit above the chosen lane equals bit 15 of the constant, and every bit below the lane equals `in_old`.
- R5: Bits 5:0 of the instruction appear on `wr_index` whenever `wr_valid` is high.
- R6: A destination index of 0 never raises `wr_valid`.
- R7: If 16k is at or beyond the register width, `wr_valid` stays low and `lane_err` is high for exactly the one result cycle of that instruction.
- R8: `wr_valid` and `lane_err` are registered: they reflect the instruction presented with `in_valid` high on the previous clock edge, and both are low after a cycle with `in_valid` low.
- R9: While `rst_n` is low, `wr_valid`, `lane_err`, `wr_index` and `wr_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Instruction word |
| in_old | input | REG_W | Current destination register contents |
| wr_valid | output | 1 | Write-back strobe |
| wr_index | output | 6 | Destination register index |
| wr_data | output | REG_W | Value to write back |
| lane_err | output | 1 | Lane lies outside the register, one-cycle pulse |

## Verification
The bench builds the unit with the default 64-bit width. That gives four legal lanes and twelve out-of-range lane numbers, so both the topmost legal lane and the first illegal one are reachable. Lane 3 is the case where sign extension has nothing above it to fill, and lane 0 is the case where there is nothing below to preserve. Directed cases cover both constant signs at every lane and both variants, and a stream of random instructions then mixes foreign opcodes, register zero and idle cycles.

// File: rtl/cli_pkg.sv
package cli_pkg;
    localparam int LANE_W  = 16;
    localparam int SHIFT_W = 4;
    localparam int IDX_W   = 6;
    localparam int OPC_W   = 5;

    typedef struct packed {
        logic               hit;
        logic               sext;
        logic [SHIFT_W-1:0] lane;
        logic [LANE_W-1:0]  imm;
        logic [IDX_W-1:0]   dest;
    } cli_dec_t;
endpackage

// File: rtl/cli_decode.sv
module cli_decode
    import cli_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPC_MATCH = 5'b10110,
    parameter int               NUM_LANES = 4
) (
    input  logic [31:0] instr,
    output cli_dec_t    dec,
    output logic        lane_ok
);
    always_comb begin
        dec.hit  = (instr[31:27] == OPC_MATCH);
        dec.sext = instr[26];
        dec.lane = instr[25:22];
        dec.imm  = instr[21:6];
        dec.dest = instr[5:0];
        lane_ok  = ({28'd0, dec.lane} < 32'(NUM_LANES));
    end
endmodule

// File: rtl/cli_lane_merge.sv
module cli_lane_merge
    import cli_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int REG_W    = NUM_LANES * LANE_W
) (
    input  logic [REG_W-1:0] old_val,
    input  cli_dec_t         dec,
    output logic [REG_W-1:0] merged
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic [SHIFT_W-1:0] SEL = SHIFT_W'(g);
        logic [LANE_W-1:0] word;
        always_comb begin
            if (dec.lane == SEL)
                word = dec.imm;
            else if (dec.sext && (dec.lane < SEL))
                word = {LANE_W{dec.imm[LANE_W-1]}};
            else
                word = old_val[g*LANE_W +: LANE_W];
        end
        assign merged[g*LANE_W +: LANE_W] = word;
    end
endmodule

// File: rtl/const_lane_insert.sv
module const_lane_insert
    import cli_pkg::*;
#(
    parameter int               REG_W     = 64,
    parameter logic [OPC_W-1:0] OPC_MATCH = 5'b10110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_instr,
    input  logic [REG_W-1:0] in_old,
    output logic             wr_valid,
    output logic [IDX_W-1:0] wr_index,
    output logic [REG_W-1:0] wr_data,
    output logic             lane_err
);
    localparam int NUM_LANES = REG_W / LANE_W;

    typedef struct packed {
        logic             wr_valid;
        logic             lane_err;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] data;
    } state_t;

    cli_dec_t         dec;
    logic             lane_ok;
    logic [REG_W-1:0] merged;
    state_t           st_d, st_q;

    cli_decode #(.OPC_MATCH(OPC_MATCH), .NUM_LANES(NUM_LANES)) u_dec (
        .instr   (in_instr),
        .dec     (dec),
        .lane_ok (lane_ok)
    );

    cli_lane_merge #(.NUM_LANES(NUM_LANES)) u_merge (
        .old_val (in_old),
        .dec     (dec),
        .merged  (merged)
    );

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        st_d.lane_err = 1'b0;
        if (in_valid && dec.hit) begin
            st_d.lane_err = !lane_ok;
            st_d.wr_valid = lane_ok && (dec.dest != '0);
            st_d.idx      = dec.dest;
            if (lane_ok)
                st_d.data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_valid = st_q.wr_valid;
    assign lane_err = st_q.lane_err;
    assign wr_index = st_q.idx;
    assign wr_data  = st_q.data;

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_valid && !lane_err));

    p_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_instr[31:27] != OPC_MATCH)) |=> (!wr_valid && !lane_err));

    p_no_r0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_index != '0));

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lane_err |-> !wr_valid);

    p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lane_err |-> $past(in_valid));

    p_keep_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.hit && lane_ok && (dec.lane != '0) && (dec.dest != '0))
        |=> (wr_data[LANE_W-1:0] == $past(in_old[LANE_W-1:0])));
endmodule

// File: tb/const_lane_insert_test.sv
module const_lane_insert_test;
    localparam int W = 64;
    localparam logic [4:0] OPC = 5'b10110;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_instr = '0;
    logic [W-1:0] in_old = '0;
    logic         wr_valid, lane_err;
    logic [5:0]   wr_index;
    logic [W-1:0] wr_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit           e_wv, e_err, e_have;
    logic [5:0]   e_idx;
    logic [W-1:0] e_data;
    string        e_tag;

    always #2 clk = ~clk;

    const_lane_insert #(.REG_W(W), .OPC_MATCH(OPC)) uut (
        .clk, .rst_n, .in_valid, .in_instr, .in_old,
        .wr_valid, .wr_index, .wr_data, .lane_err
    );

    function automatic logic [31:0] mk(input logic [4:0] op, input bit sx,
                                       input int lane, input logic [15:0] imm,
                                       input int dest);
        return {op, sx, 4'(lane), imm, 6'(dest)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        if (!e_have) return;
        chk(wr_valid == e_wv, e_tag, "wr_valid", 64'(wr_valid), 64'(e_wv));
        chk(lane_err == e_err, e_err ? "R7" : e_tag, "lane_err", 64'(lane_err), 64'(e_err));
        if (e_wv) begin
            chk(wr_index == e_idx, "R5", "wr_index", 64'(wr_index), 64'(e_idx));
            chk(wr_data == e_data, "R2 R3 R4", "wr_data", wr_data, e_data);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] ins, input logic [W-1:0] old);
        bit hit, sx;
        int lane, lo, dest;
        logic [15:0] imm;
        @(negedge clk);
        compare();
        in_valid = v; in_instr = ins; in_old = old;
        hit = (ins[31:27] == OPC); sx = ins[26]; lane = int'(ins[25:22]);
        imm = ins[21:6]; dest = int'(ins[5:0]); lo = lane * 16;
        e_have = 1;
        e_err  = v && hit && (lo >= W);
        e_wv   = v && hit && (lo < W) && (dest != 0);
        e_idx  = 6'(dest);
        if (!v)            e_tag = "R8";
        else if (!hit)     e_tag = "R1";
        else if (lo >= W)  e_tag = "R7";
        else if (dest == 0) e_tag = "R6";
        else               e_tag = "R8";
        for (int b = 0; b < W; b++) begin
            if (b >= lo && b < lo + 16) e_data[b] = imm[b - lo];
            else if (b >= lo + 16 && sx) e_data[b] = imm[15];
            else e_data[b] = old[b];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        e_have = 0;
        repeat (3) @(negedge clk);
        // R9: outputs held at zero during reset
        chk(!wr_valid && !lane_err, "R9", "strobes", 64'({wr_valid, lane_err}), 64'd0);
        chk(wr_data == '0 && wr_index == '0, "R9", "data", wr_data, 64'd0);
        rst_n = 1'b1;
        // R2/R3: plain variant at every lane
        for (int k = 0; k < 4; k++)
            step(1, mk(OPC, 0, k, 16'hA5C3 ^ 16'(k), 7 + k), 64'h0123_4567_89AB_CDEF);
        // R4: extending variant, negative and positive constants
        for (int k = 0; k < 4; k++) begin
            step(1, mk(OPC, 1, k, 16'h8001, 9), 64'h1111_2222_3333_4444);
            step(1, mk(OPC, 1, k, 16'h7FFE, 10), 64'hFFFF_EEEE_DDDD_CCCC);
        end
        // R6: register zero
        step(1, mk(OPC, 0, 1, 16'h1234, 0), 64'h5);
        step(1, mk(OPC, 1, 2, 16'hFFFF, 0), 64'h6);
        // R7: lanes beyond width, first illegal and the last encoding
        step(1, mk(OPC, 0, 4, 16'h1234, 3), 64'h7);
        step(1, mk(OPC, 1, 15, 16'h8000, 0), 64'h8);
        step(1, mk(OPC, 0, 2, 16'h4321, 4), 64'h9);
        // R1: foreign opcodes
        step(1, mk(5'b10111, 0, 1, 16'hBEEF, 5), 64'hA);
        step(1, mk(5'b00110, 1, 5, 16'hBEEF, 5), 64'hB);
        // R8: idle cycles
        step(0, mk(OPC, 0, 0, 16'hCAFE, 6), 64'hC);
        step(0, mk(OPC, 0, 9, 16'hCAFE, 6), 64'hD);
        // mixed random stream
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            if ($urandom % 4 != 0) r[31:27] = OPC;
            step(($urandom % 5) != 0, r, {$urandom, $urandom});
        end
        step(0, '0, '0);
        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule